// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Wrap Flag

This block multiplies an A_W-bit operand by a B_W-bit operand and folds the product into a running sum that is A_W+B_W+16 bits wide. The sum lives in a register that is always present. Each enabled cycle adds the product to the sum, subtracts it from the sum, or replaces the sum with an external preload value. A registered flag reports that the latest step left the range of the sum. The range is two's complement when the signed control is high and plain binary when it is low.

An optional input register stage and an optional pipeline stage sit in front of the accumulator. Both carry the operands, the preload value and the three controls (signed, add/subtract, load), so a control always acts on the product it was issued with. Each operand can come from the normal data input or from a shift-in input. The operand that the input stage captured is presented again on a shift-out port, so neighbouring units can be chained. One clock enable freezes every register. A synchronous reset clears all of them.

Each enabled cycle, the accumulator picks one action: OP_LOAD when the staged load control is high, otherwise OP_ADD or OP_SUB according to add/subtract. When the enable is low it picks OP_HOLD. The choice is remade every cycle. Any action can follow any other, and reset forces the registers back to zero, which acts as an unsigned subtraction of zero.

Top module: `mac_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `acc_out`, `ovf`, `a_so`, `b_so` and every stage register, whatever `ce` is.
- R2: With both optional stages present (default), inputs sampled at an enabled edge affect `acc_out` and `ovf` at the second enabled edge after it. Each optional stage that is removed shortens this by one edge.
- R3: `add_nsub` = 1 adds the product to the sum; `add_nsub` = 0 subtracts it. The result is taken modulo 2^(A_W+B_W+16).
- R4: `is_signed` = 1 treats both operands as two's complement and sign-extends the product. `is_signed` = 0 treats them as unsigned and zero-extends the product.
- R5: `load` = 1 replaces the sum with `load_val` and clears `ovf`, whatever `add_nsub` and the operands are.
- R6: In signed mode, `ovf` is 1 exactly when the true signed result of the step lies outside the two's complement range of the sum. It returns to 0 on the next step that does not wrap.
- R7: In unsigned mode, `ovf` is 1 exactly when an add produces a carry out of the top bit or a subtract needs a borrow.
- R8: While `ce` is 0, `acc_out`, `ovf`, `a_so`, `b_so` and all staged values keep their values.
- R9: `shift_sel` = 1 takes the operands from `a_si`/`b_si` instead of `a_in`/`b_in`. `a_so`/`b_so` show the operands captured at the last enabled edge.
- R10: Controls stay aligned with their operands: a stream whose mode, direction and load change every cycle gives the same sums as applying each step in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every register |
| a_in | input | A_W | Operand A data input |
| b_in | input | B_W | Operand B data input |
| a_si | input | A_W | Operand A shift-in |
| b_si | input | B_W | Operand B shift-in |
| shift_sel | input | 1 | 1 selects shift-in operands |
| is_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| add_nsub | input | 1 | 1 = add product, 0 = subtract |
| load | input | 1 | 1 = replace sum with load_val |
| load_val | input | A_W+B_W+16 | Preload value |
| a_so | output | A_W | Operand A shift-out |
| b_so | output | B_W | Operand B shift-out |
| acc_out | output | A_W+B_W+16 | Accumulated sum |
| ovf | output | 1 | Registered wrap flag of the last step |

## Verification
Two functions can meet at the same edge: a step that wraps and raises `ovf`, and a load that clears it. The bench sets up both cases with directed sequences. In one, a preload near the top of the range is followed by a wrapping add, and a load is issued on the very next cycle. In the other, a load carries a large product with add selected, to show that the load wins. The same overlap also comes up in the random stream, which mixes loads of values near the range boundaries with wrapping steps. Each cycle is judged against a bench function that steps a reference sum one issued operation at a time, two enabled edges behind the issue edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_LOAD = 2'd3
    } acc_op_e;

    typedef struct packed {
        logic sgn;
        logic add;
        logic ld;
    } ctl_t;

    localparam int CTL_W = 3;

endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (EN) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r <= '0;
                end else if (ce) begin
                    q_r <= d;
                end
            end
            assign q = q_r;
        end else begin : g_pass
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int A_W   = 8,
    parameter int B_W   = 8,
    parameter int ACC_W = 32
) (
    input  logic [A_W-1:0]   a,
    input  logic [B_W-1:0]   b,
    input  logic             sgn,
    output logic [ACC_W-1:0] prod_ext
);

    localparam int PW = A_W + B_W + 2;

    logic signed [A_W:0]  a_x;
    logic signed [B_W:0]  b_x;
    logic signed [PW-1:0] prod;

    always_comb begin
        a_x      = {sgn & a[A_W-1], a};
        b_x      = {sgn & b[B_W-1], b};
        prod     = PW'(a_x) * PW'(b_x);
        prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  ctl_t             ctl,
    input  logic [ACC_W-1:0] prod,
    input  logic [ACC_W-1:0] ld_val,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);

    localparam int MSB = ACC_W - 1;

    acc_op_e          op;
    logic [ACC_W:0]   wide;
    logic [ACC_W-1:0] nxt_acc;
    logic             nxt_ovf;

    always_comb begin
        if (!ce) begin
            op = OP_HOLD;
        end else if (ctl.ld) begin
            op = OP_LOAD;
        end else if (ctl.add) begin
            op = OP_ADD;
        end else begin
            op = OP_SUB;
        end
    end

    always_comb begin
        wide    = '0;
        nxt_acc = acc;
        nxt_ovf = ovf;
        unique case (op)
            OP_HOLD: begin
                nxt_acc = acc;
                nxt_ovf = ovf;
            end
            OP_LOAD: begin
                nxt_acc = ld_val;
                nxt_ovf = 1'b0;
            end
            OP_ADD: begin
                wide    = {1'b0, acc} + {1'b0, prod};
                nxt_acc = wide[ACC_W-1:0];
                nxt_ovf = ctl.sgn ? ((acc[MSB] == prod[MSB]) && (nxt_acc[MSB] != acc[MSB]))
                                  : wide[ACC_W];
            end
            OP_SUB: begin
                wide    = {1'b0, acc} - {1'b0, prod};
                nxt_acc = wide[ACC_W-1:0];
                nxt_ovf = ctl.sgn ? ((acc[MSB] != prod[MSB]) && (nxt_acc[MSB] != acc[MSB]))
                                  : wide[ACC_W];
            end
            default: begin
                nxt_acc = acc;
                nxt_ovf = ovf;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else begin
            acc <= nxt_acc;
            ovf <= nxt_ovf;
        end
    end

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(acc) && $stable(ovf))) else $error("hold"); // R8

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ce && ctl.ld) |=> (!ovf && acc == $past(ld_val))) else $error("load"); // R5

    AST_UNS_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (ce && !ctl.ld && ctl.add && !ctl.sgn) |=> (ovf == (acc < $past(acc)))) else $error("carry"); // R7

    AST_UNS_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
        (ce && !ctl.ld && !ctl.add && !ctl.sgn) |=> (ovf == (acc > $past(acc)))) else $error("borrow"); // R7

    AST_SGN_POS_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ce && !ctl.ld && ctl.add && ctl.sgn && !prod[MSB])
        |=> (ovf == ($signed(acc) < $signed($past(acc))))) else $error("signed wrap"); // R6

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int A_W      = 8,
    parameter int B_W      = 8,
    parameter int GUARD_W  = 16,
    parameter bit IN_REG   = 1'b1,
    parameter bit PIPE_REG = 1'b1,
    localparam int ACC_W   = A_W + B_W + GUARD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    input  logic [A_W-1:0]   a_si,
    input  logic [B_W-1:0]   b_si,
    input  logic             shift_sel,
    input  logic             is_signed,
    input  logic             add_nsub,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    output logic [A_W-1:0]   a_so,
    output logic [B_W-1:0]   b_so,
    output logic [ACC_W-1:0] acc_out,
    output logic             ovf
);

    localparam int S1_W = ACC_W + CTL_W + A_W + B_W;
    localparam int S2_W = ACC_W + CTL_W + ACC_W;

    ctl_t             ctl_in, s1_ctl, s2_ctl;
    logic [A_W-1:0]   a_pick, s1_a;
    logic [B_W-1:0]   b_pick, s1_b;
    logic [ACC_W-1:0] s1_ld, s2_ld, prod, s2_prod;
    logic [S1_W-1:0]  s1_d, s1_q;
    logic [S2_W-1:0]  s2_d, s2_q;

    always_comb begin
        a_pick = shift_sel ? a_si : a_in;
        b_pick = shift_sel ? b_si : b_in;
        ctl_in = '{sgn: is_signed, add: add_nsub, ld: load};
        s1_d   = {load_val, ctl_in, a_pick, b_pick};
    end

    mac_stage #(.W(S1_W), .EN(IN_REG)) u_in_stage (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .d   (s1_d),
        .q   (s1_q)
    );

    assign {s1_ld, s1_ctl, s1_a, s1_b} = s1_q;
    assign a_so = s1_a;
    assign b_so = s1_b;

    mac_mult #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_mult (
        .a        (s1_a),
        .b        (s1_b),
        .sgn      (s1_ctl.sgn),
        .prod_ext (prod)
    );

    assign s2_d = {s1_ld, s1_ctl, prod};

    mac_stage #(.W(S2_W), .EN(PIPE_REG)) u_pipe_stage (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .d   (s2_d),
        .q   (s2_q)
    );

    assign {s2_ld, s2_ctl, s2_prod} = s2_q;

    mac_accum #(.ACC_W(ACC_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .ctl    (s2_ctl),
        .prod   (s2_prod),
        .ld_val (s2_ld),
        .acc    (acc_out),
        .ovf    (ovf)
    );

    generate
        if (IN_REG) begin : g_so_chk
            AST_SO_FROZEN: assert property (@(posedge clk) disable iff (rst)
                !ce |=> ($stable(a_so) && $stable(b_so))) else $error("shift-out"); // R8
            AST_SO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
                (ce && shift_sel) |=> (a_so == $past(a_si) && b_so == $past(b_si))) else $error("shift-in"); // R9
        end
    endgenerate

endmodule

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;

    localparam int AW = 8;
    localparam int BW = 8;
    localparam int CW = AW + BW + 16;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        logic          sg;
        logic          ad;
        logic          ld;
        logic [CW-1:0] lv;
    } op_t;

    logic clk = 1'b0;
    logic rst, ce, shift_sel, is_signed, add_nsub, load;
    logic [AW-1:0] a_in, a_si, a_so;
    logic [BW-1:0] b_in, b_si, b_so;
    logic [CW-1:0] load_val, acc_out;
    logic ovf;

    op_t p0, p1;
    logic [CW-1:0] m_acc;
    logic m_ovf;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mac_unit u_mac_unit (
        .clk(clk), .rst(rst), .ce(ce), .a_in(a_in), .b_in(b_in),
        .a_si(a_si), .b_si(b_si), .shift_sel(shift_sel), .is_signed(is_signed),
        .add_nsub(add_nsub), .load(load), .load_val(load_val),
        .a_so(a_so), .b_so(b_so), .acc_out(acc_out), .ovf(ovf)
    );

    function automatic logic [CW:0] step(logic [CW-1:0] acc, op_t o);
        longint pr, r, lo, hi;
        logic [63:0] rv;
        if (o.ld) return {1'b0, o.lv};
        if (o.sg) pr = longint'($signed(o.a)) * longint'($signed(o.b));
        else      pr = longint'(o.a) * longint'(o.b);
        if (o.sg) begin
            r  = longint'($signed(acc)) + (o.ad ? pr : -pr);
            lo = -(longint'(1) <<< (CW - 1));
            hi = (longint'(1) <<< (CW - 1)) - 1;
        end else begin
            r  = longint'(acc) + (o.ad ? pr : -pr);
            lo = 0;
            hi = (longint'(1) <<< CW) - 1;
        end
        rv = r;
        return {(r < lo) || (r > hi), rv[CW-1:0]};
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic c, logic sh, logic [AW-1:0] a, logic [BW-1:0] b,
                       logic sg, logic ad, logic ld, logic [CW-1:0] lv,
                       logic [AW-1:0] asi, logic [BW-1:0] bsi);
        op_t o;
        ce = c; shift_sel = sh; a_in = a; b_in = b; a_si = asi; b_si = bsi;
        is_signed = sg; add_nsub = ad; load = ld; load_val = lv;
        o = '{a: (sh ? asi : a), b: (sh ? bsi : b), sg: sg, ad: ad, ld: ld, lv: lv};
        @(posedge clk);
        if (c) begin
            {m_ovf, m_acc} = step(m_acc, p1);
            p1 = p0;
            p0 = o;
        end
        @(negedge clk);
        check(tag, "acc_out", 64'(acc_out), 64'(m_acc));
        check(tag, "ovf", 64'(ovf), 64'(m_ovf));
        check(tag, "a_so", 64'(a_so), 64'(p0.a));
        check(tag, "b_so", 64'(b_so), 64'(p0.b));
    endtask

    task automatic op(string tag, logic [AW-1:0] a, logic [BW-1:0] b, logic sg, logic ad);
        cyc(tag, 1'b1, 1'b0, a, b, sg, ad, 1'b0, '0, '0, '0);
    endtask

    task automatic ldv(string tag, logic [CW-1:0] v);
        cyc(tag, 1'b1, 1'b0, 8'hA5, 8'h5A, 1'b1, 1'b1, 1'b1, v, '0, '0);
    endtask

    task automatic nop(string tag, int n);
        for (int i = 0; i < n; i++) op(tag, '0, '0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        p0 = '0; p1 = '0; m_acc = '0; m_ovf = 1'b0;
        rst = 1'b1; ce = 1'b0; shift_sel = 1'b0; a_in = 8'hFF; b_in = 8'hFF;
        a_si = 8'h11; b_si = 8'h22; is_signed = 1'b1; add_nsub = 1'b1; load = 1'b0; load_val = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "acc_out", 64'(acc_out), 64'd0);
        check("R1", "ovf", 64'(ovf), 64'd0);
        check("R1", "a_so", 64'(a_so), 64'd0);
        check("R1", "b_so", 64'(b_so), 64'd0);
        rst = 1'b0;

        // R2 latency, R3 add/sub, R5 load
        ldv("R5", 32'd100);
        op("R3", 8'd3, 8'd4, 1'b0, 1'b1);
        op("R3", 8'd2, 8'd5, 1'b0, 1'b0);
        nop("R2", 2);
        // R4 signed versus unsigned with the same bits
        ldv("R4", 32'd0);
        op("R4", 8'hFD, 8'd5, 1'b1, 1'b1);
        op("R4", 8'hFD, 8'd5, 1'b0, 1'b1);
        op("R4", 8'h80, 8'h80, 1'b1, 1'b0);
        nop("R4", 2);
        // R6 signed wrap up and down, then clearing
        ldv("R6", 32'h7FFF_FF00);
        op("R6", 8'd127, 8'd127, 1'b1, 1'b1);
        op("R6", 8'd0, 8'd0, 1'b1, 1'b1);
        ldv("R6", 32'h8000_0010);
        op("R6", 8'd127, 8'd127, 1'b1, 1'b0);
        nop("R6", 2);
        // R7 unsigned carry and borrow
        ldv("R7", 32'hFFFF_FF00);
        op("R7", 8'd255, 8'd255, 1'b0, 1'b1);
        ldv("R7", 32'd5);
        op("R7", 8'd2, 8'd3, 1'b0, 1'b0);
        nop("R7", 2);
        // R5 load right after a wrapping step; load wins over add
        ldv("R5", 32'hFFFF_FFF0);
        op("R5", 8'd255, 8'd255, 1'b0, 1'b1);
        cyc("R5", 1'b1, 1'b0, 8'd255, 8'd255, 1'b0, 1'b1, 1'b1, 32'h1234_5678, '0, '0);
        nop("R5", 2);
        // R8 enable low freezes everything
        op("R8", 8'd9, 8'd9, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++)
            cyc("R8", 1'b0, 1'b0, 8'(i * 7), 8'd200, 1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF, '0, '0);
        nop("R8", 2);
        // R9 shift-in selection
        cyc("R9", 1'b1, 1'b1, 8'hEE, 8'hEE, 1'b0, 1'b1, 1'b0, '0, 8'd9, 8'd7);
        cyc("R9", 1'b1, 1'b1, 8'h01, 8'h01, 1'b1, 1'b0, 1'b0, '0, 8'hF0, 8'd3);
        nop("R9", 2);
        // R10 random mixed stream
        for (int i = 0; i < 4000; i++) begin
            logic [CW-1:0] v;
            logic [2:0] k;
            k = 3'($urandom % 5);
            v = $urandom;
            case (k)
                3'd1: v[CW-1:CW-16] = 16'h7FFF;
                3'd2: v[CW-1:CW-16] = 16'h8000;
                3'd3: v[CW-1:CW-16] = 16'hFFFF;
                3'd4: v[CW-1:CW-16] = 16'h0000;
                default: ;
            endcase
            cyc("R10", ($urandom % 8) != 0, ($urandom % 4) == 0, 8'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), ($urandom % 10) == 0, v, 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule